// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the coherence state of every line in a small group of private caches that share one snooping bus in front of a common next-level memory. Each cache line is in one of four states: Invalid, Shared, Exclusive or Modified. Each core presents a read or write request for a line index. A round-robin arbiter grants one request per cycle. The granted request is turned into one of three bus transactions (read, read-for-ownership or invalidate), or into no bus transaction when the local state already allows the access.

In the grant cycle, every other cache looks up the same line. A wired-OR of their hits decides whether a read miss lands in Shared or Exclusive. A peer that holds the line dirty is asked to write it back. All state changes, for the requester and for the peers, take effect on the clock edge that ends the grant cycle. A probe port reads back the state of any line in every cache. Data arrays, replacement and the memory itself are not modelled.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line of every cache is Invalid (state code 0), no grant is given and the bus command is none (code 0). State codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- R2: A granted read to an Invalid line with no peer holding the line issues a read (bus code 1), keeps shared_hit low and puts the line in Exclusive.
- R3: A granted read to an Invalid line that some peer holds issues a read with shared_hit high and puts the line in Shared. A peer in Exclusive or Shared moves to, or stays in, Shared, with no write-back.
- R4: When such a read finds a peer in Modified, that peer's bit in wb_req is high in the grant cycle and the peer ends in Shared.
- R5: A granted write to an Invalid line issues a read-for-ownership (bus code 2) and puts the requester in Modified. Every peer ends Invalid, and a peer that was in Modified has its wb_req bit high in the grant cycle.
- R6: A granted write to a Shared line issues an invalidate (bus code 3). All peers go to Invalid and the requester goes to Modified.
- R7: A granted write to an Exclusive line moves it to Modified with bus command none, shared_hit low and wb_req zero.
- R8: A granted read or write to a Modified line, and a granted read to a Shared or Exclusive line, give bus command none and leave the line's state unchanged.
- R9: At most one grant is given per cycle. Priority starts at the core after the last granted one, and wraps from the highest core to core 0 (core 0 first after reset). An ungranted request stays pending.
- R10: No line is ever held in Exclusive or Modified by more than one cache at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CORES | Per-core request pending |
| req_write | input | N_CORES | Per-core request is a write |
| req_line | input | N_CORES*LW | Per-core line index, core c at bits [c*LW +: LW] |
| probe_line | input | LW | Line whose state is read back on probe_state |
| gnt | output | N_CORES | One-hot grant, this cycle |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| bus_line | output | LW | Line of the granted request |
| bus_src | output | CW | Index of the granted core |
| shared_hit | output | 1 | OR of peer hits, valid with a bus command |
| wb_req | output | N_CORES | Per-core dirty write-back request |
| probe_state | output | 2*N_CORES | State of probe_line, core c at bits [2c +: 2] |

## Verification
The grant and all bus outputs (gnt, bus_cmd, bus_line, bus_src, shared_hit, wb_req) are combinational in the cycle the request is presented. Line states change on the next rising edge. The driver presents each request just after a rising edge and queues the expected bus item; the monitor compares against it on the falling edge of the same cycle. State checks are made through the probe port one step after the following rising edge, before any new request can be granted. For the concurrent-request case, the expected grant order is derived from the last core the bench saw granted.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int N_CORES = 4,
  parameter int N_LINES = 8,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CORES-1:0]      req_valid,
  input  logic [N_CORES-1:0]      req_write,
  input  logic [N_CORES*LW-1:0]   req_line,
  input  logic [LW-1:0]           probe_line,
  output logic [N_CORES-1:0]      gnt,
  output logic [1:0]              bus_cmd,
  output logic [LW-1:0]           bus_line,
  output logic [CW-1:0]           bus_src,
  output logic                    shared_hit,
  output logic [N_CORES-1:0]      wb_req,
  output logic [2*N_CORES-1:0]    probe_state
);

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RFO = 2'd2, CMD_INV = 2'd3;

  logic [1:0] st [N_CORES][N_LINES];
  logic [CW-1:0] ptr;
  logic found;
  logic [CW-1:0] src;
  logic [LW-1:0] line;
  logic wr;
  logic [1:0] own, own_nxt;
  logic [N_CORES-1:0] phit, pmod;
  logic any_peer;
  logic [1:0] cmd;

  always_comb begin
    found = 1'b0;
    src = '0;
    for (int k = 0; k < N_CORES; k++) begin
      int i;
      i = (int'(ptr) + k) % N_CORES;
      if (!found && req_valid[i]) begin
        found = 1'b1;
        src = CW'(i);
      end
    end
  end

  assign line = req_line[src*LW +: LW];
  assign wr   = req_write[src];
  assign own  = st[src][line];

  always_comb begin
    for (int k = 0; k < N_CORES; k++) begin
      phit[k] = (k != int'(src)) && (st[k][line] != ST_I);
      pmod[k] = (k != int'(src)) && (st[k][line] == ST_M);
    end
  end

  assign any_peer = |phit;

  always_comb begin
    cmd = CMD_NONE;
    if (found) begin
      if (wr) cmd = (own == ST_I) ? CMD_RFO : (own == ST_S) ? CMD_INV : CMD_NONE;
      else    cmd = (own == ST_I) ? CMD_RD : CMD_NONE;
    end
  end

  always_comb begin
    if (wr)               own_nxt = ST_M;
    else if (own == ST_I) own_nxt = any_peer ? ST_S : ST_E;
    else                  own_nxt = own;
  end

  assign gnt        = found ? (N_CORES'(1) << src) : '0;
  assign bus_cmd    = cmd;
  assign bus_line   = line;
  assign bus_src    = src;
  assign shared_hit = (cmd != CMD_NONE) && any_peer;
  assign wb_req     = (cmd == CMD_RD || cmd == CMD_RFO) ? pmod : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int c = 0; c < N_CORES; c++)
        for (int l = 0; l < N_LINES; l++)
          st[c][l] <= ST_I;
    end else if (found) begin
      ptr <= (int'(src) == N_CORES - 1) ? '0 : src + CW'(1);
      for (int k = 0; k < N_CORES; k++) begin
        if (k == int'(src))
          st[k][line] <= own_nxt;
        else if (cmd == CMD_RD && phit[k])
          st[k][line] <= ST_S;
        else if (cmd == CMD_RFO || cmd == CMD_INV)
          st[k][line] <= ST_I;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < N_CORES; c++)
      probe_state[2*c +: 2] = st[c][probe_line];
  end

  logic [1:0]         cmd_q;
  logic [LW-1:0]      line_q;
  logic [CW-1:0]      src_q;
  logic [N_CORES-1:0] wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NONE; line_q <= '0; src_q <= '0; wb_q <= '0;
    end else begin
      cmd_q <= cmd; line_q <= line; src_q <= src; wb_q <= wb_req;
    end
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req_valid) == '0));

  // R5
  rfo_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RFO) |-> (st[src_q][line_q] == ST_M));

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [N_CORES-1:0] excl;
    for (genvar c = 0; c < N_CORES; c++) begin : g_c
      assign excl[c] = st[c][l][1];
    end
    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(excl) <= 1);
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_wb
    // R4
    wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_q[c] |-> (st[c][line_q] != ST_M));
  end

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int N = 4;
  localparam int L = 8;
  localparam int LW = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_valid = '0, req_write = '0;
  logic [N*LW-1:0] req_line = '0;
  logic [LW-1:0] probe_line = '0;
  logic [N-1:0] gnt, wb_req;
  logic [1:0] bus_cmd;
  logic [LW-1:0] bus_line;
  logic [CW-1:0] bus_src;
  logic shared_hit;
  logic [2*N-1:0] probe_state;

  int checks = 0, errors = 0;

  typedef struct {
    logic [1:0] cmd; int line; int src; bit sh; logic [N-1:0] wb; string tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.N_CORES(N), .N_LINES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .probe_line(probe_line), .gnt(gnt), .bus_cmd(bus_cmd),
    .bus_line(bus_line), .bus_src(bus_src), .shared_hit(shared_hit),
    .wb_req(wb_req), .probe_state(probe_state));

  always @(negedge clk) begin
    if (rst_n && |gnt) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected grant: got gnt=%b cmd=%0d expected no grant", gnt, bus_cmd);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (bus_cmd !== e.cmd || int'(bus_line) != e.line || int'(bus_src) != e.src ||
            shared_hit !== e.sh || wb_req !== e.wb || gnt !== (N'(1) << e.src)) begin
          errors++;
          $display("FAIL %s: got cmd=%0d line=%0d src=%0d sh=%b wb=%b gnt=%b expected cmd=%0d line=%0d src=%0d sh=%b wb=%b",
                   e.tag, bus_cmd, bus_line, bus_src, shared_hit, wb_req, gnt,
                   e.cmd, e.line, e.src, e.sh, e.wb);
        end
      end
    end
  end

  task automatic issue(int c, bit w, int l, logic [1:0] cmd, bit sh, logic [N-1:0] wb, string tag);
    @(posedge clk); #1;
    req_valid[c] = 1'b1; req_write[c] = w; req_line[c*LW +: LW] = LW'(l);
    exp_q.push_back('{cmd, l, c, sh, wb, tag});
    @(posedge clk); #1;
    req_valid[c] = 1'b0;
  endtask

  task automatic chk(int c, int l, logic [1:0] e, string tag);
    logic [1:0] got;
    probe_line = LW'(l); #1;
    got = probe_state[2*c +: 2];
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: core %0d line %0d state got %0d expected %0d", tag, c, l, got, e);
    end
  endtask

  task automatic chk_owner(int l);
    int n;
    probe_line = LW'(l); #1;
    n = 0;
    for (int c = 0; c < N; c++) if (probe_state[2*c+1]) n++;
    checks++;
    if (n > 1) begin
      errors++;
      $display("FAIL R10: line %0d exclusive/modified holders got %0d expected at most 1", l, n);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int l = 0; l < L; l++)
      for (int c = 0; c < N; c++) chk(c, l, 2'd0, "R1");
    @(negedge clk);
    checks++;
    if (gnt !== '0 || bus_cmd !== 2'd0) begin
      errors++;
      $display("FAIL R1: got gnt=%b cmd=%0d expected 0 0", gnt, bus_cmd);
    end

    // R2 read miss, no peers
    issue(0, 0, 1, 2'd1, 0, 4'b0000, "R2");
    chk(0, 1, 2'd2, "R2");
    // R8 read hit on Exclusive
    issue(0, 0, 1, 2'd0, 0, 4'b0000, "R8");
    chk(0, 1, 2'd2, "R8");
    // R3 read miss with peer in Exclusive
    issue(1, 0, 1, 2'd1, 1, 4'b0000, "R3");
    chk(0, 1, 2'd1, "R3"); chk(1, 1, 2'd1, "R3");
    // R8 read hit on Shared
    issue(1, 0, 1, 2'd0, 0, 4'b0000, "R8");
    chk(1, 1, 2'd1, "R8");
    // R5 write miss, peers Shared
    issue(2, 1, 1, 2'd2, 1, 4'b0000, "R5");
    chk(0, 1, 2'd0, "R5"); chk(1, 1, 2'd0, "R5"); chk(2, 1, 2'd3, "R5");
    chk_owner(1);
    // R4 read miss, peer Modified
    issue(3, 0, 1, 2'd1, 1, 4'b0100, "R4");
    chk(2, 1, 2'd1, "R4"); chk(3, 1, 2'd1, "R4");
    // R6 write hit on Shared
    issue(3, 1, 1, 2'd3, 1, 4'b0000, "R6");
    chk(2, 1, 2'd0, "R6"); chk(3, 1, 2'd3, "R6");
    chk_owner(1);
    // R8 hits on Modified
    issue(3, 1, 1, 2'd0, 0, 4'b0000, "R8");
    issue(3, 0, 1, 2'd0, 0, 4'b0000, "R8");
    chk(3, 1, 2'd3, "R8");
    // R5 write miss with dirty peer
    issue(0, 1, 2, 2'd2, 0, 4'b0000, "R5");
    chk(0, 2, 2'd3, "R5");
    issue(1, 1, 2, 2'd2, 1, 4'b0001, "R5");
    chk(0, 2, 2'd0, "R5"); chk(1, 2, 2'd3, "R5");
    chk_owner(2);
    // R7 silent upgrade
    issue(2, 0, 3, 2'd1, 0, 4'b0000, "R7");
    chk(2, 3, 2'd2, "R7");
    issue(2, 1, 3, 2'd0, 0, 4'b0000, "R7");
    chk(2, 3, 2'd3, "R7");
    // R4 again on another line
    issue(1, 0, 3, 2'd1, 1, 4'b0100, "R4");
    chk(1, 3, 2'd1, "R4"); chk(2, 3, 2'd1, "R4");
    chk_owner(3);

    // R9 round robin: last grant was core 1, so order is 2,3,0,1
    @(posedge clk); #1;
    for (int c = 0; c < N; c++) begin
      req_valid[c] = 1'b1; req_write[c] = 1'b0; req_line[c*LW +: LW] = LW'(4 + c);
    end
    for (int k = 0; k < N; k++) begin
      int c;
      c = (2 + k) % N;
      exp_q.push_back('{2'd1, 4 + c, c, 1'b0, 4'b0000, "R9"});
    end
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] g;
      @(negedge clk); g = gnt;
      @(posedge clk); #1;
      req_valid = req_valid & ~g;
    end
    for (int c = 0; c < N; c++) chk(c, 4 + c, 2'd2, "R9");

    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: got %0d pending grants expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule